// File: doc/BRIEF.md
# Programmable Fringe Rate Rotator

This block turns a time-multiplexed stream of real antenna samples into phase-rotated I and Q samples. Every channel keeps its own phase accumulator, which grows by a programmed rate word each time a sample of that channel passes. The upper bits of the accumulator are added to a per-channel start angle. The sum addresses one sine/cosine table, and all channels share that table because only one sample enters per cycle. Between software updates the hardware keeps moving the phase on its own.

Software writes new start angles and rate words into staging registers ahead of time. They do nothing until the load trigger fires at the scheduled instant. At that point every channel takes its staged settings at once and restarts its accumulator from zero. This keeps several nodes that share the same load time in step with each other.

Top module: `fringe_rotator`

## Requirements
- R1: While reset is asserted, and after its release, out_valid, out_chan, out_i and out_q are zero. Each channel's active start angle, active rate and accumulator are zero until the first load.
- R2: The table entry k (k = 0..1023) holds cos = int'(2047·cos(2πk/1024)) and sin = int'(2047·sin(2πk/1024)), each 12-bit signed. int'() rounds to nearest. For an input x (12-bit signed), out_i = x·cos and out_q = x·sin, as 24-bit signed products.
- R3: The table address of a sample is (active start angle + accumulator bits [45:36]) mod 1024. The accumulator value used is the one before the sample's own advance.
- R4: The 46-bit accumulator of a channel grows by its zero-extended 32-bit rate on every valid sample of that channel, and wraps modulo 2^46.
- R5: A register write stores into staging only. cfg_field = 0 writes the low 10 bits of cfg_data as the start angle; cfg_field = 1 writes all 32 bits as the rate. The output seen for later samples does not change until a load.
- R6: A cycle with load_strobe high copies the staging values of all channels into the active settings and clears every accumulator. The new settings apply from the next sample on.
- R7: A sample of one channel leaves the accumulators of all other channels unchanged.
- R8: Each valid input gives a valid output exactly two clock cycles later, with out_chan equal to the input's channel. Cycles without a valid input give no valid output two cycles later.
- R9: A sample that enters in the same cycle as a load uses the settings from before that load. A register write in the same cycle as a load is not part of that load.
- R10: The angle sum wraps, so a start angle of 1020 plus accumulator angle 5 addresses entry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample present this cycle |
| in_chan | input | 2 | Channel of the input sample |
| in_data | input | 12 | Real input sample, signed |
| cfg_wr | input | 1 | Write strobe for a staging register |
| cfg_chan | input | 2 | Channel addressed by the write |
| cfg_field | input | 1 | 0 = start angle, 1 = rate word |
| cfg_data | input | 32 | Write data |
| load_strobe | input | 1 | Scheduled-time trigger that applies staged values |
| out_valid | output | 1 | Rotated sample present |
| out_chan | output | 2 | Channel of the rotated sample |
| out_i | output | 24 | In-phase product, signed |
| out_q | output | 24 | Quadrature product, signed |

## Verification
Two registers lie between a sample and its result. The first holds the table address, the sample and its channel. The second holds the products. So the rotated value for a sample driven before edge n appears after edge n+1. The bench drives on the falling edge and checks on the next falling edge, after one more rising edge. Each check compares against the expectation stored one step earlier. The effects of writes and loads show only through that same two-cycle path: a load in step n changes the result of the sample in step n+1, which is checked at the end of step n+2. The sample that enters with the load is checked against the old settings.

// File: rtl/frot_pkg.sv
package frot_pkg;
  localparam int unsigned FROT_NUM_CH  = 4;
  localparam int unsigned FROT_DATA_W  = 12;
  localparam int unsigned FROT_COEF_W  = 12;
  localparam int unsigned FROT_ANG_W   = 10;
  localparam int unsigned FROT_RATE_W  = 32;
  localparam int unsigned FROT_ACC_W   = 46;
  localparam logic        FLD_ANGLE    = 1'b0;
  localparam logic        FLD_RATE     = 1'b1;
endpackage

// File: rtl/frot_stage.sv
module frot_stage #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ANG_W  = 10,
  parameter int unsigned RATE_W = 32,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic [CH_W-1:0]                wr_chan_i,
  input  logic                           wr_field_i,
  input  logic [RATE_W-1:0]              wr_data_i,
  input  logic                           load_i,
  output logic [NUM_CH-1:0][ANG_W-1:0]   act_start_o,
  output logic [NUM_CH-1:0][RATE_W-1:0]  act_rate_o
);
  import frot_pkg::*;

  logic [NUM_CH-1:0][ANG_W-1:0]  stg_start_q, stg_start_d;
  logic [NUM_CH-1:0][RATE_W-1:0] stg_rate_q,  stg_rate_d;
  logic [NUM_CH-1:0][ANG_W-1:0]  act_start_q, act_start_d;
  logic [NUM_CH-1:0][RATE_W-1:0] act_rate_q,  act_rate_d;

  always_comb begin
    stg_start_d = stg_start_q;
    stg_rate_d  = stg_rate_q;
    if (wr_i) begin
      if (wr_field_i == FLD_RATE) stg_rate_d[wr_chan_i]  = wr_data_i;
      else                        stg_start_d[wr_chan_i] = wr_data_i[ANG_W-1:0];
    end
    act_start_d = load_i ? stg_start_q : act_start_q;
    act_rate_d  = load_i ? stg_rate_q  : act_rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_start_q <= '0;
      stg_rate_q  <= '0;
      act_start_q <= '0;
      act_rate_q  <= '0;
    end else begin
      if (wr_i) begin
        stg_start_q <= stg_start_d;
        stg_rate_q  <= stg_rate_d;
      end
      if (load_i) begin
        act_start_q <= act_start_d;
        act_rate_q  <= act_rate_d;
      end
    end
  end

  assign act_start_o = act_start_q;
  assign act_rate_o  = act_rate_q;

  // Active settings move only on a load (R5)
  assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(act_start_o) && $stable(act_rate_o)));

  // A load takes the staged values as they stood before that cycle's write (R6, R9)
  assert_load_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (act_rate_o == $past(stg_rate_q) && act_start_o == $past(stg_start_q)));
endmodule

// File: rtl/frot_phase_acc.sv
module frot_phase_acc #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ANG_W  = 10,
  parameter int unsigned RATE_W = 32,
  parameter int unsigned ACC_W  = 46,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           adv_i,
  input  logic [CH_W-1:0]                chan_i,
  input  logic                           load_i,
  input  logic [NUM_CH-1:0][ANG_W-1:0]   start_i,
  input  logic [NUM_CH-1:0][RATE_W-1:0]  rate_i,
  output logic [ANG_W-1:0]               addr_o
);
  logic [NUM_CH-1:0][ACC_W-1:0] acc_q, acc_d;
  logic acc_en;

  assign acc_en = load_i | adv_i;

  always_comb begin
    acc_d = acc_q;
    if (load_i)     acc_d = '0;
    else if (adv_i) acc_d[chan_i] = acc_q[chan_i] + ACC_W'(rate_i[chan_i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  // Angle wraps by width: start + top accumulator bits, modulo 2^ANG_W
  assign addr_o = start_i[chan_i] + acc_q[chan_i][ACC_W-1 -: ANG_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // Untouched channels keep their phase (R7)
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !(adv_i && chan_i == CH_W'(c))) |=> $stable(acc_q[c]));
    // A load restarts every accumulator (R6)
    assert_load_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (acc_q[c] == '0));
  end
endmodule

// File: rtl/frot_trig_lut.sv
module frot_trig_lut #(
  parameter int unsigned ANG_W  = 10,
  parameter int unsigned COEF_W = 12
) (
  input  logic [ANG_W-1:0]         addr_i,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o
);
  localparam int unsigned TBL_N = 1 << ANG_W;
  localparam real AMP = real'((1 << (COEF_W - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic signed [COEF_W-1:0] cos_tab [TBL_N];
  logic signed [COEF_W-1:0] sin_tab [TBL_N];

  for (genvar k = 0; k < TBL_N; k++) begin : g_tab
    localparam real PH = TWO_PI * real'(k) / real'(TBL_N);
    assign cos_tab[k] = COEF_W'(int'(AMP * $cos(PH)));
    assign sin_tab[k] = COEF_W'(int'(AMP * $sin(PH)));
  end

  assign cos_o = cos_tab[addr_i];
  assign sin_o = sin_tab[addr_i];
endmodule

// File: rtl/fringe_rotator.sv
module fringe_rotator #(
  parameter int unsigned NUM_CH = frot_pkg::FROT_NUM_CH,
  parameter int unsigned DATA_W = frot_pkg::FROT_DATA_W,
  parameter int unsigned COEF_W = frot_pkg::FROT_COEF_W,
  parameter int unsigned ANG_W  = frot_pkg::FROT_ANG_W,
  parameter int unsigned RATE_W = frot_pkg::FROT_RATE_W,
  parameter int unsigned ACC_W  = frot_pkg::FROT_ACC_W,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned OUT_W = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [CH_W-1:0]          in_chan,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     cfg_wr,
  input  logic [CH_W-1:0]          cfg_chan,
  input  logic                     cfg_field,
  input  logic [RATE_W-1:0]        cfg_data,
  input  logic                     load_strobe,
  output logic                     out_valid,
  output logic [CH_W-1:0]          out_chan,
  output logic signed [OUT_W-1:0]  out_i,
  output logic signed [OUT_W-1:0]  out_q
);
  // Reset synchronizer: asserts at once, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_CH-1:0][ANG_W-1:0]  act_start;
  logic [NUM_CH-1:0][RATE_W-1:0] act_rate;
  logic [ANG_W-1:0]              addr;

  frot_stage #(.NUM_CH(NUM_CH), .ANG_W(ANG_W), .RATE_W(RATE_W), .CH_W(CH_W)) i_stage (
    .clk(clk), .rst_n(rst_int_n),
    .wr_i(cfg_wr), .wr_chan_i(cfg_chan), .wr_field_i(cfg_field), .wr_data_i(cfg_data),
    .load_i(load_strobe),
    .act_start_o(act_start), .act_rate_o(act_rate)
  );

  frot_phase_acc #(.NUM_CH(NUM_CH), .ANG_W(ANG_W), .RATE_W(RATE_W), .ACC_W(ACC_W), .CH_W(CH_W))
    i_acc (
    .clk(clk), .rst_n(rst_int_n),
    .adv_i(in_valid), .chan_i(in_chan), .load_i(load_strobe),
    .start_i(act_start), .rate_i(act_rate),
    .addr_o(addr)
  );

  // Stage 1: table address, sample and channel
  logic                     s1_valid_q;
  logic [CH_W-1:0]          s1_chan_q;
  logic [ANG_W-1:0]         s1_addr_q;
  logic signed [DATA_W-1:0] s1_data_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_valid_q <= 1'b0;
      s1_chan_q  <= '0;
      s1_addr_q  <= '0;
      s1_data_q  <= '0;
    end else begin
      s1_valid_q <= in_valid;
      if (in_valid) begin
        s1_chan_q <= in_chan;
        s1_addr_q <= addr;
        s1_data_q <= in_data;
      end
    end
  end

  logic signed [COEF_W-1:0] cos_v, sin_v;

  frot_trig_lut #(.ANG_W(ANG_W), .COEF_W(COEF_W)) i_lut (
    .addr_i(s1_addr_q), .cos_o(cos_v), .sin_o(sin_v)
  );

  // Stage 2: rotation products
  logic signed [OUT_W-1:0] prod_i_d, prod_q_d;
  assign prod_i_d = OUT_W'(s1_data_q * cos_v);
  assign prod_q_d = OUT_W'(s1_data_q * sin_v);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s1_valid_q;
      if (s1_valid_q) begin
        out_chan <= s1_chan_q;
        out_i    <= prod_i_d;
        out_q    <= prod_q_d;
      end
    end
  end

  // Two-cycle input-to-output latency (R8)
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |-> ##2 (out_valid && out_chan == $past(in_chan, 2)));
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |-> ##2 !out_valid);
endmodule

// File: tb/test_fringe_rotator.sv
`timescale 1ns/1ps
module test_fringe_rotator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_chan;
  logic signed [11:0] in_data;
  logic        cfg_wr;
  logic [1:0]  cfg_chan;
  logic        cfg_field;
  logic [31:0] cfg_data;
  logic        load_strobe;
  logic        out_valid;
  logic [1:0]  out_chan;
  logic signed [23:0] out_i, out_q;

  always #2.5 clk = ~clk;

  fringe_rotator i_fringe_rotator (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
    .cfg_wr(cfg_wr), .cfg_chan(cfg_chan), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .load_strobe(load_strobe),
    .out_valid(out_valid), .out_chan(out_chan), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  logic [45:0] m_acc   [4];
  logic [9:0]  m_start [4];
  logic [31:0] m_rate  [4];
  logic [9:0]  s_start [4];
  logic [31:0] s_rate  [4];

  bit      e_vld;
  int      e_chan;
  longint  e_i, e_q;

  typedef struct packed {
    logic        vld;
    logic [1:0]  ch;
    logic [11:0] x;
    logic        ld;
    logic        wr;
    logic [1:0]  wch;
    logic        wfld;
    logic [31:0] wdat;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 12'd0,    1'b0, 1'b1, 2'd0, 1'b0, 32'd256},
    '{1'b0, 2'd0, 12'd0,    1'b0, 1'b1, 2'd0, 1'b1, 32'h8000_0000},
    '{1'b1, 2'd0, 12'd1000, 1'b0, 1'b0, 2'd0, 1'b0, 32'd0},
    '{1'b0, 2'd0, 12'd0,    1'b1, 1'b0, 2'd0, 1'b0, 32'd0},
    '{1'b1, 2'd0, 12'd1000, 1'b0, 1'b0, 2'd0, 1'b0, 32'd0},
    '{1'b1, 2'd0, 12'hE0C,  1'b0, 1'b0, 2'd0, 1'b0, 32'd0},
    '{1'b0, 2'd0, 12'd0,    1'b0, 1'b1, 2'd1, 1'b0, 32'd100},
    '{1'b0, 2'd0, 12'd0,    1'b0, 1'b1, 2'd1, 1'b1, 32'hFFFF_FFFF},
    '{1'b1, 2'd0, 12'd700,  1'b1, 1'b1, 2'd2, 1'b0, 32'd333},
    '{1'b1, 2'd1, 12'h800,  1'b0, 1'b0, 2'd0, 1'b0, 32'd0},
    '{1'b1, 2'd2, 12'd2047, 1'b0, 1'b0, 2'd0, 1'b0, 32'd0},
    '{1'b0, 2'd0, 12'd0,    1'b0, 1'b0, 2'd0, 1'b0, 32'd0},
    '{1'b1, 2'd0, 12'd1,    1'b0, 1'b0, 2'd0, 1'b0, 32'd0},
    '{1'b1, 2'd1, 12'd123,  1'b0, 1'b0, 2'd0, 1'b0, 32'd0},
    '{1'b0, 2'd0, 12'd0,    1'b0, 1'b0, 2'd0, 1'b0, 32'd0}
  };

  function automatic int tcos(int a);
    return int'(2047.0 * $cos(6.283185307179586 * real'(a) / 1024.0));
  endfunction
  function automatic int tsin(int a);
    return int'(2047.0 * $sin(6.283185307179586 * real'(a) / 1024.0));
  endfunction

  task automatic check(string tag, bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock step: drive at the falling edge, model it, compare the previous step's result
  task automatic step(string tag, bit vld, int ch, int x, bit ld,
                      bit wr, int wch, bit wfld, logic [31:0] wdat);
    bit     n_vld;
    int     n_chan, a;
    longint n_i, n_q;
    in_valid = vld; in_chan = 2'(ch); in_data = 12'(x);
    load_strobe = ld; cfg_wr = wr; cfg_chan = 2'(wch); cfg_field = wfld; cfg_data = wdat;
    n_vld = vld; n_chan = ch; n_i = 0; n_q = 0;
    if (vld) begin
      a = (int'(m_start[ch]) + int'(m_acc[ch][45:36])) % 1024;
      n_i = longint'(x) * tcos(a);
      n_q = longint'(x) * tsin(a);
    end
    if (ld) begin
      for (int c = 0; c < 4; c++) begin
        m_start[c] = s_start[c]; m_rate[c] = s_rate[c]; m_acc[c] = '0;
      end
    end else if (vld) m_acc[ch] = m_acc[ch] + 46'(m_rate[ch]);
    if (wr) begin
      if (wfld) s_rate[wch] = wdat;
      else      s_start[wch] = wdat[9:0];
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, out_valid == e_vld, "out_valid", longint'(out_valid), longint'(e_vld));
    if (e_vld) begin
      check(tag, int'(out_chan) == e_chan, "out_chan", longint'(out_chan), longint'(e_chan));
      check(tag, longint'(out_i) == e_i, "out_i", longint'(out_i), e_i);
      check(tag, longint'(out_q) == e_q, "out_q", longint'(out_q), e_q);
    end
    e_vld = n_vld; e_chan = n_chan; e_i = n_i; e_q = n_q;
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 32'd0);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_acc[c] = '0; m_start[c] = '0; m_rate[c] = '0; s_start[c] = '0; s_rate[c] = '0;
    end
    e_vld = 0; e_chan = 0; e_i = 0; e_q = 0;
    in_valid = 0; in_chan = 0; in_data = 0; cfg_wr = 0; cfg_chan = 0;
    cfg_field = 0; cfg_data = 0; load_strobe = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check("R1", out_valid == 1'b0 && out_i == 0 && out_q == 0 && out_chan == 0,
          "outputs in reset", longint'(out_i), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", out_valid == 1'b0, "out_valid after release", longint'(out_valid), 0);

    // R1: before any load, angle is zero -> I = x*2047, Q = 0
    step("R1", 1'b1, 3, 1000, 1'b0, 1'b0, 0, 1'b0, 32'd0);
    idle("R1");

    // Vector table: R2 products, R3 addressing, R5 staging, R6 load, R9 same-cycle load, R8 channel tag
    for (int v = 0; v < NV; v++)
      step("R2/R3/R5/R6/R8/R9", VECS[v].vld, int'(VECS[v].ch), int'($signed(VECS[v].x)),
           VECS[v].ld, VECS[v].wr, int'(VECS[v].wch), VECS[v].wfld, VECS[v].wdat);

    // R10 and R4: start 1020, fast rate, run across the angle wrap
    step("R10", 1'b0, 0, 0, 1'b0, 1'b1, 3, 1'b0, 32'd1020);
    step("R10", 1'b0, 0, 0, 1'b0, 1'b1, 3, 1'b1, 32'hFFFF_FFFF);
    step("R6",  1'b0, 0, 0, 1'b1, 1'b0, 0, 1'b0, 32'd0);
    for (int n = 0; n < 120; n++)
      step("R4/R10", 1'b1, 3, 1500 - 25 * n, 1'b0, 1'b0, 0, 1'b0, 32'd0);

    // R7: channel 2 untouched by channel 3 traffic
    step("R7", 1'b1, 2, -777, 1'b0, 1'b0, 0, 1'b0, 32'd0);

    // R5: staging writes without load leave channel 3 on its running phase
    step("R5", 1'b0, 0, 0, 1'b0, 1'b1, 3, 1'b0, 32'd0);
    step("R5", 1'b0, 0, 0, 1'b0, 1'b1, 3, 1'b1, 32'd0);
    for (int n = 0; n < 20; n++)
      step("R5", 1'b1, 3, 911, 1'b0, 1'b0, 0, 1'b0, 32'd0);

    // R9: write in the load cycle is not part of that load
    step("R9", 1'b1, 3, 400, 1'b1, 1'b1, 3, 1'b0, 32'd512);
    step("R9", 1'b1, 3, 400, 1'b0, 1'b0, 0, 1'b0, 32'd0);
    step("R6", 1'b0, 0, 0, 1'b1, 1'b0, 0, 1'b0, 32'd0);
    step("R6", 1'b1, 3, 400, 1'b0, 1'b0, 0, 1'b0, 32'd0);
    idle("R8");
    idle("R8");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule